// File: doc/BRIEF.md
# Integer Shift and Rotate Unit with Opcode Decoder

This block executes the shift and rotate class of a 64-bit integer instruction set. It receives a 32-bit instruction word together with the values of its two source registers (called rj and rk below). It decodes the word into one of sixteen operations: logical left, logical right, arithmetic right and rotate right. Each of the four comes in a register-amount form and an immediate-amount form, at word (32-bit) or doubleword (64-bit) width. The unit returns the destination register index, a valid flag and the 64-bit result.

Word operations work on the low 32 bits of rj only and sign-extend their 32-bit result to 64 bits. Doubleword operations use all 64 bits unchanged. With the parameter `OUT_REG` at its default of 1, all three outputs are registered, which adds one clock of latency. With `OUT_REG` at 0 the unit is purely combinational.

Top module: `shift_rot_unit`

## Requirements
- R1: Register-form operations carry rd in bits 4:0, rj in bits 9:5 and rk in bits 14:10, and are selected by the 17-bit value in bits 31:15: 0x0002E word left, 0x0002F word logical right, 0x00030 word arithmetic right, 0x00036 word rotate, 0x00031 doubleword left, 0x00032 doubleword logical right, 0x00033 doubleword arithmetic right, 0x00037 doubleword rotate. The dst_idx output carries rd.
- R2: Word immediate forms are selected by bits 31:15 equal to 0x00081 (left), 0x00089 (logical right), 0x00091 (arithmetic right) or 0x00099 (rotate), and take a 5-bit amount from bits 14:10.
- R3: Doubleword immediate forms are selected by bits 31:16 equal to 0x0041 (left), 0x0045 (logical right), 0x0049 (arithmetic right) or 0x004D (rotate), and take a 6-bit amount from bits 15:10.
- R4: In register form, only the low 5 bits of rk set the amount for word operations and only the low 6 bits for doubleword operations. Higher bits of rk have no effect.
- R5: Word logical shifts act on the low 32 bits of rj, with zeros filled in. Bit 31 of the result is copied into bits 63:32.
- R6: A word arithmetic right shift fills with bit 31 of rj, ignoring bit 63, and sign-extends its result to 64 bits.
- R7: A word rotate right rotates within the low 32 bits and sign-extends the rotated value to 64 bits.
- R8: Doubleword operations use all 64 bits of rj and apply no extension.
- R9: An instruction word that matches none of the sixteen patterns gives res_valid low, result zero and dst_idx zero.
- R10: An amount of zero returns the source unchanged: all of rj for doubleword operations, and the sign-extended low 32 bits for word operations.
- R11: With OUT_REG=1, the outputs follow the inputs one rising clock edge later. While rst is high at an edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word to decode |
| src_j | input | 64 | Value of the first source register (rj) |
| src_k | input | 64 | Value of the second source register (rk), used for register-form amounts |
| dst_idx | output | 5 | Destination register index, zero when not valid |
| res_valid | output | 1 | High when insn is one of the sixteen operations |
| result | output | 64 | Shift or rotate result, zero when not valid |

## Verification
Under the default configuration every result is due exactly one rising edge after its stimulus. The bench drives insn and operands on a falling edge and samples the outputs on the next falling edge, so exactly one register stage lies between stimulus and check. A separate scenario samples shortly after a new stimulus and before the following rising edge, and confirms that the outputs still hold the previous result. Expected values come from a bit-by-bit reference model in the bench, evaluated over random operands and the boundary amounts 0, 31, 32 and 63.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int XLEN    = 64;
    localparam int HLEN    = XLEN / 2;
    localparam int AW      = $clog2(XLEN);
    localparam int HAW     = $clog2(HLEN);
    localparam int ILEN    = 32;
    localparam int RIDX_W  = 5;

    // 17-bit selectors (bits 31:15): register forms
    localparam logic [16:0] SEL_R_LL_W = 17'h0002E;
    localparam logic [16:0] SEL_R_RL_W = 17'h0002F;
    localparam logic [16:0] SEL_R_RA_W = 17'h00030;
    localparam logic [16:0] SEL_R_LL_D = 17'h00031;
    localparam logic [16:0] SEL_R_RL_D = 17'h00032;
    localparam logic [16:0] SEL_R_RA_D = 17'h00033;
    localparam logic [16:0] SEL_R_RR_W = 17'h00036;
    localparam logic [16:0] SEL_R_RR_D = 17'h00037;
    // 17-bit selectors: word immediate forms
    localparam logic [16:0] SEL_I_LL_W = 17'h00081;
    localparam logic [16:0] SEL_I_RL_W = 17'h00089;
    localparam logic [16:0] SEL_I_RA_W = 17'h00091;
    localparam logic [16:0] SEL_I_RR_W = 17'h00099;
    // 16-bit selectors (bits 31:16): doubleword immediate forms
    localparam logic [15:0] SEL_I_LL_D = 16'h0041;
    localparam logic [15:0] SEL_I_RL_D = 16'h0045;
    localparam logic [15:0] SEL_I_RA_D = 16'h0049;
    localparam logic [15:0] SEL_I_RR_D = 16'h004D;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_LRGT  = 2'd1,
        SK_ARGT  = 2'd2,
        SK_ROTR  = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic              vld;
        shift_kind_e       kind;
        logic              word;
        logic              from_reg;
        logic [AW-1:0]     imm_amt;
        logic [RIDX_W-1:0] rd;
    } shift_dec_t;

    function automatic logic [XLEN-1:0] sext_half(input logic [HLEN-1:0] v);
        return {{HLEN{v[HLEN-1]}}, v};
    endfunction
endpackage

// File: rtl/srt_decode.sv
module srt_decode
    import srt_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output shift_dec_t      dec
);
    logic [16:0] sel17;
    logic [15:0] sel16;
    logic        hit_reg, hit_wimm, hit_dimm;
    shift_kind_e kind;
    logic        word;

    assign sel17 = insn[31:15];
    assign sel16 = insn[31:16];

    always_comb begin
        hit_reg  = 1'b0;
        hit_wimm = 1'b0;
        hit_dimm = 1'b0;
        kind     = SK_LEFT;
        word     = 1'b0;
        case (sel17)
            SEL_R_LL_W: begin hit_reg = 1'b1; kind = SK_LEFT; word = 1'b1; end
            SEL_R_RL_W: begin hit_reg = 1'b1; kind = SK_LRGT; word = 1'b1; end
            SEL_R_RA_W: begin hit_reg = 1'b1; kind = SK_ARGT; word = 1'b1; end
            SEL_R_RR_W: begin hit_reg = 1'b1; kind = SK_ROTR; word = 1'b1; end
            SEL_R_LL_D: begin hit_reg = 1'b1; kind = SK_LEFT; end
            SEL_R_RL_D: begin hit_reg = 1'b1; kind = SK_LRGT; end
            SEL_R_RA_D: begin hit_reg = 1'b1; kind = SK_ARGT; end
            SEL_R_RR_D: begin hit_reg = 1'b1; kind = SK_ROTR; end
            SEL_I_LL_W: begin hit_wimm = 1'b1; kind = SK_LEFT; word = 1'b1; end
            SEL_I_RL_W: begin hit_wimm = 1'b1; kind = SK_LRGT; word = 1'b1; end
            SEL_I_RA_W: begin hit_wimm = 1'b1; kind = SK_ARGT; word = 1'b1; end
            SEL_I_RR_W: begin hit_wimm = 1'b1; kind = SK_ROTR; word = 1'b1; end
            default: ;
        endcase
        case (sel16)
            SEL_I_LL_D: begin hit_dimm = 1'b1; kind = SK_LEFT; end
            SEL_I_RL_D: begin hit_dimm = 1'b1; kind = SK_LRGT; end
            SEL_I_RA_D: begin hit_dimm = 1'b1; kind = SK_ARGT; end
            SEL_I_RR_D: begin hit_dimm = 1'b1; kind = SK_ROTR; end
            default: ;
        endcase
    end

    always_comb begin
        dec.vld      = hit_reg | hit_wimm | hit_dimm;
        dec.kind     = kind;
        dec.word     = word;
        dec.from_reg = hit_reg;
        dec.imm_amt  = hit_dimm ? insn[10 +: AW] : {1'b0, insn[10 +: HAW]};
        dec.rd       = insn[RIDX_W-1:0];
    end

    // R1, R2, R3: the three encoding groups never claim the same word
    always_comb begin
        assert_one_group_R1: assert ($onehot0({hit_reg, hit_wimm, hit_dimm}))
            else $error("decoder matched more than one encoding group");
    end
endmodule

// File: rtl/srt_shifter.sv
module srt_shifter
    import srt_pkg::*;
(
    input  shift_dec_t      dec,
    input  logic [XLEN-1:0] src_j,
    input  logic [XLEN-1:0] src_k,
    output logic [XLEN-1:0] res
);
    logic [AW-1:0]     amt_d;
    logic [HAW-1:0]    amt_w;
    logic [HLEN-1:0]   wsrc, wres;
    logic [2*HLEN-1:0] wrot;
    logic [2*XLEN-1:0] drot;
    logic [XLEN-1:0]   dres;

    assign amt_d = dec.from_reg ? src_k[AW-1:0] : dec.imm_amt;
    assign amt_w = amt_d[HAW-1:0];
    assign wsrc  = src_j[HLEN-1:0];
    assign wrot  = {wsrc, wsrc} >> amt_w;
    assign drot  = {src_j, src_j} >> amt_d;

    always_comb begin
        unique case (dec.kind)
            SK_LEFT: wres = wsrc << amt_w;
            SK_LRGT: wres = wsrc >> amt_w;
            SK_ARGT: wres = HLEN'($signed(wsrc) >>> amt_w);
            SK_ROTR: wres = wrot[HLEN-1:0];
        endcase
        unique case (dec.kind)
            SK_LEFT: dres = src_j << amt_d;
            SK_LRGT: dres = src_j >> amt_d;
            SK_ARGT: dres = XLEN'($signed(src_j) >>> amt_d);
            SK_ROTR: dres = drot[XLEN-1:0];
        endcase
        res = dec.word ? sext_half(wres) : dres;
    end

    // R10: a zero amount leaves a doubleword source untouched
    always_comb begin
        if (dec.vld && !dec.word && amt_d == '0) begin
            assert_zero_amount_R10: assert (res == src_j)
                else $error("zero-amount doubleword result differs from source");
        end
    end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import srt_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ILEN-1:0]   insn,
    input  logic [XLEN-1:0]   src_j,
    input  logic [XLEN-1:0]   src_k,
    output logic [RIDX_W-1:0] dst_idx,
    output logic              res_valid,
    output logic [XLEN-1:0]   result
);
    shift_dec_t        dec;
    logic [XLEN-1:0]   sh_res;
    logic [XLEN-1:0]   c_result;
    logic [RIDX_W-1:0] c_dst;

    srt_decode  u_dec (.insn(insn), .dec(dec));
    srt_shifter u_sh  (.dec(dec), .src_j(src_j), .src_k(src_k), .res(sh_res));

    assign c_result = dec.vld ? sh_res : '0;
    assign c_dst    = dec.vld ? dec.rd : '0;

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_valid <= 1'b0;
                    dst_idx   <= '0;
                    result    <= '0;
                end else begin
                    res_valid <= dec.vld;
                    dst_idx   <= c_dst;
                    result    <= c_result;
                end
            end

            assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
                dec.vld |=> res_valid);
            assert_invalid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
                !dec.vld |=> (result == '0 && dst_idx == '0 && !res_valid));
            assert_word_sext_R5: assert property (@(posedge clk) disable iff (rst)
                (dec.vld && dec.word) |=> (result[XLEN-1:HLEN] == {HLEN{result[HLEN-1]}}));
            assert_dst_follows_R1: assert property (@(posedge clk) disable iff (rst)
                dec.vld |=> (dst_idx == $past(insn[RIDX_W-1:0])));
        end else begin : g_comb
            assign res_valid = dec.vld;
            assign dst_idx   = c_dst;
            assign result    = c_result;
        end
    endgenerate
endmodule

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = 32'hFFFF_FFFF;
    logic [63:0] src_j = '0;
    logic [63:0] src_k = '0;
    logic [4:0]  dst_idx;
    logic        res_valid;
    logic [63:0] result;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // kind order: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right
    logic [16:0] reg_w  [4] = '{17'h0002E, 17'h0002F, 17'h00030, 17'h00036};
    logic [16:0] reg_d  [4] = '{17'h00031, 17'h00032, 17'h00033, 17'h00037};
    logic [16:0] imm_w  [4] = '{17'h00081, 17'h00089, 17'h00091, 17'h00099};
    logic [15:0] imm_d  [4] = '{16'h0041, 16'h0045, 16'h0049, 16'h004D};
    int          bnd    [4] = '{0, 31, 32, 63};

    shift_rot_unit u_shift_rot_unit (
        .clk(clk), .rst(rst), .insn(insn), .src_j(src_j), .src_k(src_k),
        .dst_idx(dst_idx), .res_valid(res_valid), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] model(int kind, bit word, logic [63:0] a, int amt);
        int n = word ? 32 : 64;
        int s = amt % n;
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: r[i] = (i >= s) ? a[i-s] : 1'b0;
                1: r[i] = (i + s < n) ? a[i+s] : 1'b0;
                2: r[i] = (i + s < n) ? a[i+s] : a[n-1];
                default: r[i] = a[(i+s)%n];
            endcase
        end
        if (word) for (int i = 32; i < 64; i++) r[i] = r[31];
        return r;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(string req, logic [31:0] w, logic [63:0] a, logic [63:0] b,
                         bit ev, logic [4:0] ed, logic [63:0] er);
        @(negedge clk);
        insn = w; src_j = a; src_k = b;
        @(negedge clk);
        n_vec++;
        if (res_valid !== ev || dst_idx !== ed || result !== er) begin
            n_fail++;
            $display("FAIL %s insn=%h: got v=%0b d=%0d r=%h, expected v=%0b d=%0d r=%h",
                     req, w, res_valid, dst_idx, result, ev, ed, er);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        insn = {reg_d[0], 5'd3, 5'd2, 5'd9};
        src_j = 64'h1; src_k = 64'h4;
        repeat (2) @(negedge clk);
        n_vec++;
        if (res_valid !== 1'b0 || dst_idx !== 5'd0 || result !== 64'd0) begin
            n_fail++;
            $display("FAIL R11 reset: got v=%0b d=%0d r=%h, expected v=0 d=0 r=0",
                     res_valid, dst_idx, result);
        end
        rst = 1'b0;
    endtask

    // R1 R4 R5 R6 R7 R8: register forms, boundary and random amounts, junk in high rk bits
    task automatic t_register_forms();
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 8; j++) begin
                logic [63:0] a = (j == 0) ? 64'h8000_0001_8765_4321 : rnd64();
                int amt = (j < 4) ? bnd[j] : int'($urandom_range(0, 63));
                logic [63:0] b = {rnd64()} & ~64'h3F | 64'(amt);
                logic [4:0] rd = 5'($urandom_range(0, 31));
                check("R1/R4/R5-R7 word reg", {reg_w[k], 5'd7, 5'd4, rd}, a, b, 1'b1, rd,
                      model(k, 1'b1, a, amt % 32));
                check("R1/R4/R8 dword reg", {reg_d[k], 5'd7, 5'd4, rd}, a, b, 1'b1, rd,
                      model(k, 1'b0, a, amt));
            end
        end
    endtask

    // R6: bit 63 set but bit 31 clear must not fill a word arithmetic shift
    task automatic t_word_arith_fill();
        check("R6", {reg_w[2], 5'd1, 5'd1, 5'd5}, 64'hFFFF_FFFF_7000_0000, 64'd4,
              1'b1, 5'd5, 64'h0000_0000_0700_0000);
        check("R6", {imm_w[2], 5'd4, 5'd1, 5'd6}, 64'h0000_0000_8000_0000, 64'd0,
              1'b1, 5'd6, 64'hFFFF_FFFF_F800_0000);
    endtask

    task automatic t_word_imm();
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 6; j++) begin
                logic [63:0] a = rnd64();
                int amt = (j < 2) ? bnd[j] : int'($urandom_range(0, 31));
                logic [4:0] rd = 5'($urandom_range(0, 31));
                check("R2 word imm", {imm_w[k], 5'(amt), 5'd3, rd}, a, rnd64(), 1'b1, rd,
                      model(k, 1'b1, a, amt));
            end
        end
    endtask

    task automatic t_dword_imm();
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 7; j++) begin
                logic [63:0] a = rnd64();
                int amt = (j < 4) ? bnd[j] : int'($urandom_range(0, 63));
                logic [4:0] rd = 5'($urandom_range(0, 31));
                check("R3 dword imm", {imm_d[k], 6'(amt), 5'd3, rd}, a, rnd64(), 1'b1, rd,
                      model(k, 1'b0, a, amt));
            end
        end
    endtask

    task automatic t_invalid();
        logic [31:0] bad [5] = '{32'hFFFF_FFFF, 32'h0000_0000, {17'h00034, 15'h1234},
                                 {17'h00080, 15'h7FFF}, {16'h0042, 16'hABCD}};
        for (int i = 0; i < 5; i++)
            check("R9 unmatched", bad[i], rnd64(), rnd64(), 1'b0, 5'd0, 64'd0);
    endtask

    task automatic t_zero_amount();
        logic [63:0] a = 64'h0123_4567_89AB_CDEF;
        for (int k = 0; k < 4; k++) begin
            check("R10 dword zero", {imm_d[k], 6'd0, 5'd2, 5'd8}, a, 64'd0, 1'b1, 5'd8, a);
            check("R10 word zero", {reg_w[k], 5'd3, 5'd2, 5'd8}, a, 64'hFFFF_FFFF_FFFF_FFE0,
                  1'b1, 5'd8, 64'hFFFF_FFFF_89AB_CDEF);
        end
    endtask

    // R11: outputs hold the previous result until the next rising edge
    task automatic t_latency();
        check("R11 first", {imm_d[0], 6'd4, 5'd1, 5'd10}, 64'h1, 64'd0, 1'b1, 5'd10, 64'h10);
        insn = {imm_d[1], 6'd1, 5'd1, 5'd11};
        src_j = 64'h100;
        #1;
        n_vec++;
        if (dst_idx !== 5'd10 || result !== 64'h10) begin
            n_fail++;
            $display("FAIL R11 early: got d=%0d r=%h, expected d=10 r=10", dst_idx, result);
        end
        @(negedge clk);
        n_vec++;
        if (dst_idx !== 5'd11 || result !== 64'h80) begin
            n_fail++;
            $display("FAIL R11 late: got d=%0d r=%h, expected d=11 r=80", dst_idx, result);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_register_forms();
        t_word_arith_fill();
        t_word_imm();
        t_dword_imm();
        t_invalid();
        t_zero_amount();
        t_latency();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule